// File: doc/BRIEF.md
# Speculative Load Check Tracker

This block sits beside a load/store pipeline that lets loads run ahead of earlier branches and stores. When such a load would fault, the pipeline hands the fault indication to the tracker instead of trapping. The tracker raises a per-register deferred-fault flag, and it records the load's address and destination register in a small associative table. Every store then compares its address against the table. A matching entry is marked stale, which means its loaded value is no longer trusted.

Later, at the point where the load originally sat in program order, the pipeline presents a check for the destination register. One cycle after the check, the tracker answers with one of three verdicts: the value is good, the load must be executed again, or the deferred fault must be raised now. Each check retires that register's entry and its fault flag. A faulting load whose check never arrives therefore never traps.

Addresses match at 8-byte granularity. Once the table is full, a load to an untracked register takes a slot picked by a rotating pointer.

Top module: `spec_load_tracker`

## Requirements
- R1: After synchronous reset (rst_n low), no entry is valid, no register carries a fault flag, and res_valid is low. The first check after reset on any register returns replay.
- R2: Each check produces exactly one result, with res_valid high in the cycle after the check request. res_code is 0 for pass, 1 for replay and 2 for raise. No result appears without a check.
- R3: A speculative load with ld_fault high produces no output of its own. A later check on its destination register returns raise.
- R4: A deferred fault is discarded when a new non-faulting speculative load to the same register arrives before any check. That register's next check then returns pass. No check means no raise.
- R5: A store matches an entry when the addresses are equal in bits [ADDR_W-1:3]. Bits [2:0] are ignored. A matched entry's next check returns replay. A store that differs in bit 3 or above leaves the entry untouched.
- R6: A check on a tracked register that has no fault flag and no matching store returns pass.
- R7: A check on a register with no valid entry and no fault flag returns replay.
- R8: A check frees the register's entry and clears its fault flag. A second check on the same register then returns replay.
- R9: A new speculative load to a register that already has an entry rewrites that entry with the new address and clears its stale mark.
- R10: A load to an untracked register uses the lowest-numbered free slot. When all ENTRIES slots are valid, it replaces the slot chosen by a rotating pointer. The pointer starts at slot 0 after reset and advances by one per replacement.
- R11: When a store and a check hit the same entry in the same cycle, the store is applied first and the check returns replay.
- R12: The fault flag takes precedence. A faulting load whose address was later matched by a store still returns raise at its check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Speculative load request |
| ld_addr | input | ADDR_W | Load address |
| ld_reg | input | $clog2(REG_CNT) | Load destination register |
| ld_fault | input | 1 | Load would have faulted |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| chk_valid | input | 1 | Check request |
| chk_reg | input | $clog2(REG_CNT) | Register being checked |
| res_valid | output | 1 | Result strobe, one cycle after a check |
| res_code | output | 2 | 0 pass, 1 replay, 2 raise |

## Verification
Clean loads show that pass is reached only when neither a fault nor an alias is present. Faulting loads, including one overwritten before its check, separate a fault that is raised from one that is silently dropped. Stores that differ only in the low three bits are compared with stores that differ in bit 3, which pins down the matching granularity. The same-cycle store-and-check case exposes the ordering between snoop and lookup. Filling the table and then adding two more loads exposes the slot choice and the rotating victim.

// File: rtl/slt_pkg.sv
// Shared types for the speculative load tracker.
// Assumes: a verdict fits in two bits; code 3 is never produced.
package slt_pkg;
    typedef enum logic [1:0] {
        VERDICT_PASS   = 2'd0,
        VERDICT_REPLAY = 2'd1,
        VERDICT_RAISE  = 2'd2
    } verdict_e;
endpackage

// File: rtl/slt_fault_flags.sv
// Per-register deferred-fault flags.
// A speculative load writes its fault indication into the flag of its destination.
// A check clears the flag of the checked register.
// When both touch one register in the same cycle, the load is applied last.
// Assumes: ld_reg and chk_reg are always below REG_CNT.
module slt_fault_flags #(
    parameter int REG_CNT = 32,
    localparam int REG_W  = $clog2(REG_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [REG_W-1:0] ld_reg,
    input  logic             ld_fault,
    input  logic             chk_valid,
    input  logic [REG_W-1:0] chk_reg,
    output logic             chk_fault
);
    logic [REG_CNT-1:0] flag_q;

    // Read the flag of the register under check.
    always_comb chk_fault = flag_q[chk_reg];

    // Update flags: the check clears first, then the load writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int r = 0; r < REG_CNT; r++) begin
                if (ld_valid && ld_reg == REG_W'(r))
                    flag_q[r] <= ld_fault;
                else if (chk_valid && chk_reg == REG_W'(r))
                    flag_q[r] <= 1'b0;
            end
        end
    end

    p_fault_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_fault) |=> flag_q[$past(ld_reg)]);

    p_fault_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !(ld_valid && ld_reg == chk_reg)) |=> !flag_q[$past(chk_reg)]);

    p_fault_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_fault) |=> !flag_q[$past(ld_reg)]);
endmodule

// File: rtl/slt_alloc.sv
// Slot chooser for the tracking table.
// Order of preference: the slot already holding the load's register,
// then the lowest free slot, then the slot under the rotating victim pointer.
// The pointer advances only when it supplies the victim.
// Assumes: at most one valid slot holds any given register.
module slt_alloc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] same_reg,
    output logic [ENTRIES-1:0] slot_sel
);
    logic [IDX_W-1:0] victim_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_same;
    logic             any_free;
    logic             take_victim;

    // Find the lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Pick the target slot as a one-hot vector.
    always_comb begin
        any_same    = |same_reg;
        any_free    = |(~ent_valid);
        take_victim = ld_valid && !any_same && !any_free;
        slot_sel    = '0;
        if (any_same)      slot_sel = same_reg;
        else if (any_free) slot_sel[free_idx] = 1'b1;
        else               slot_sel[victim_q] = 1'b1;
    end

    // Advance the rotating victim pointer after each replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            victim_q <= '0;
        else if (take_victim)
            victim_q <= (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
    end

    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $countones(slot_sel) == 1);

    p_unique_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(same_reg) <= 1);

    p_victim_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (&ent_valid) && !(|same_reg)) |=> victim_q != $past(victim_q));
endmodule

// File: rtl/slt_table.sv
// Associative table of speculative loads.
// Each slot holds a full address, a destination register and a stale mark.
// A store sets the stale mark on every slot whose address matches at line granularity.
// A check looks up its register and frees the slot it finds.
// When a load is written into a slot in the same cycle as a store or check touches it,
// the load write wins.
// Assumes: LINE_LSB < ADDR_W.
module slt_table #(
    parameter int ADDR_W   = 32,
    parameter int REG_CNT  = 32,
    parameter int ENTRIES  = 8,
    parameter int LINE_LSB = 3,
    localparam int REG_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              chk_found,
    output logic              chk_stale
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_LSB) - 1'b1);

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_stale;
    logic [ADDR_W-1:0]  ent_addr [ENTRIES];
    logic [REG_W-1:0]   ent_reg  [ENTRIES];

    logic [ENTRIES-1:0] st_hit;
    logic [ENTRIES-1:0] chk_hit;
    logic [ENTRIES-1:0] same_reg;
    logic [ENTRIES-1:0] slot_sel;
    logic [ENTRIES-1:0] ld_take;

    // Compare every slot against the store, check and load requests.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            st_hit[i]   = st_valid && ent_valid[i] &&
                          ((ent_addr[i] & LINE_MASK) == (st_addr & LINE_MASK));
            chk_hit[i]  = chk_valid && ent_valid[i] && (ent_reg[i] == chk_reg);
            same_reg[i] = ent_valid[i] && (ent_reg[i] == ld_reg);
            ld_take[i]  = ld_valid && slot_sel[i];
        end
    end

    // Report the lookup; a same-cycle store counts as already applied.
    always_comb begin
        chk_found = |chk_hit;
        chk_stale = |(chk_hit & (ent_stale | st_hit));
    end

    slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ent_valid (ent_valid),
        .same_reg  (same_reg),
        .slot_sel  (slot_sel)
    );

    // Update slots: load fill, else check free, else store invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_stale <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_addr[i] <= '0;
                ent_reg[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ld_take[i]) begin
                    ent_valid[i] <= 1'b1;
                    ent_stale[i] <= 1'b0;
                    ent_addr[i]  <= ld_addr;
                    ent_reg[i]   <= ld_reg;
                end else if (chk_hit[i]) begin
                    ent_valid[i] <= 1'b0;
                    ent_stale[i] <= 1'b0;
                end else if (st_hit[i]) begin
                    ent_stale[i] <= 1'b1;
                end
            end
        end
    end

    p_single_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_hit));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot_checks
        p_store_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_hit[g] && !chk_hit[g] && !ld_take[g]) |=> (ent_valid[g] && ent_stale[g]));

        p_check_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (chk_hit[g] && !ld_take[g]) |=> !ent_valid[g]);

        p_fill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ld_take[g] |=> (ent_valid[g] && !ent_stale[g] && ent_reg[g] == $past(ld_reg)));
    end
endmodule

// File: rtl/slt_verdict.sv
// Turns the lookup results into the registered check verdict.
// Priority: a deferred fault raises; otherwise a missing or stale entry replays;
// otherwise the check passes.
// Assumes: the lookup inputs are valid in the same cycle as chk_valid.
module slt_verdict
    import slt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     chk_valid,
    input  logic     chk_fault,
    input  logic     chk_found,
    input  logic     chk_stale,
    output logic     res_valid,
    output verdict_e res_code
);
    verdict_e code_d;

    // Choose the verdict for the current check.
    always_comb begin
        if (chk_fault)                    code_d = VERDICT_RAISE;
        else if (!chk_found || chk_stale) code_d = VERDICT_REPLAY;
        else                              code_d = VERDICT_PASS;
    end

    // Register the verdict and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= VERDICT_PASS;
        end else begin
            res_valid <= chk_valid;
            if (chk_valid) res_code <= code_d;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_code != 2'd3);

    p_fault_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_fault) |=> res_code == VERDICT_RAISE);
endmodule

// File: rtl/spec_load_tracker.sv
// Top of the speculative load tracker.
// Connects the fault flags, the associative table and the verdict stage.
// Assumes: at most one load, one store and one check per cycle.
module spec_load_tracker #(
    parameter int ADDR_W   = 32,
    parameter int REG_CNT  = 32,
    parameter int ENTRIES  = 8,
    parameter int LINE_LSB = 3,
    localparam int REG_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic              ld_fault,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              res_valid,
    output logic [1:0]        res_code
);
    import slt_pkg::*;

    logic     chk_fault;
    logic     chk_found;
    logic     chk_stale;
    verdict_e verdict;

    slt_fault_flags #(.REG_CNT(REG_CNT)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_reg    (ld_reg),
        .ld_fault  (ld_fault),
        .chk_valid (chk_valid),
        .chk_reg   (chk_reg),
        .chk_fault (chk_fault)
    );

    slt_table #(
        .ADDR_W   (ADDR_W),
        .REG_CNT  (REG_CNT),
        .ENTRIES  (ENTRIES),
        .LINE_LSB (LINE_LSB)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_reg    (ld_reg),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .chk_valid (chk_valid),
        .chk_reg   (chk_reg),
        .chk_found (chk_found),
        .chk_stale (chk_stale)
    );

    slt_verdict u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .chk_fault (chk_fault),
        .chk_found (chk_found),
        .chk_stale (chk_stale),
        .res_valid (res_valid),
        .res_code  (verdict)
    );

    // Present the verdict as a plain two-bit code.
    always_comb res_code = verdict;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !res_valid);
endmodule

// File: tb/spec_load_tracker_bench.sv
`timescale 1ns/1ps
module spec_load_tracker_bench;
    localparam int ADDR_W = 32;
    localparam int REG_W  = 5;
    localparam int PASS = 0, REPLAY = 1, RAISE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [REG_W-1:0]  ld_reg = '0;
    logic              ld_fault = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              chk_valid = 1'b0;
    logic [REG_W-1:0]  chk_reg = '0;
    logic              res_valid;
    logic [1:0]        res_code;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    int    exp_code_q[$];
    int    exp_cyc_q[$];
    string exp_tag_q[$];

    always #2.5 clk = ~clk;

    spec_load_tracker u_spec_load_tracker (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_reg(ld_reg), .ld_fault(ld_fault),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg),
        .res_valid(res_valid), .res_code(res_code)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected verdict for every strobe, compare code and cycle.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_code_q.size() == 0) begin
                check(1'b0, "R2/R4 unexpected result", int'(res_code), -1);
            end else begin
                automatic int    ec = exp_code_q.pop_front();
                automatic int    ey = exp_cyc_q.pop_front();
                automatic string et = exp_tag_q.pop_front();
                check(int'(res_code) == ec, et, int'(res_code), ec);
                check(cyc == ey, {et, " (R2 latency)"}, cyc, ey);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0; ld_fault = 1'b0;
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input int r, input bit f);
        ld_valid = 1'b1; ld_addr = a; ld_reg = REG_W'(r); ld_fault = f;
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a);
        st_valid = 1'b1; st_addr = a;
    endtask

    task automatic do_check(input int r, input int exp, input string tag);
        chk_valid = 1'b1; chk_reg = REG_W'(r);
        exp_code_q.push_back(exp);
        exp_cyc_q.push_back(cyc + 1);
        exp_tag_q.push_back(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        step();
        do_check(3, REPLAY, "R1 first check after reset"); step();

        do_load(32'h1000, 1, 0); step();
        do_check(1, PASS, "R6 clean load passes"); step();
        do_check(1, REPLAY, "R8 entry freed by check"); step();

        do_load(32'h2000, 2, 1); step();
        step(); step(); step();
        do_check(2, RAISE, "R3 deferred fault raised"); step();
        do_check(2, REPLAY, "R8 fault flag cleared"); step();

        do_load(32'h3000, 4, 1); step();
        do_load(32'h3100, 4, 0); step();
        do_check(4, PASS, "R4 unchecked fault dropped"); step();

        do_load(32'h4000, 5, 0); step();
        do_store(32'h4007); step();
        do_check(5, REPLAY, "R5 low bits ignored"); step();
        do_load(32'h5000, 6, 0); step();
        do_store(32'h5008); step();
        do_check(6, PASS, "R5 bit 3 differs"); step();

        do_load(32'h6000, 7, 0); step();
        do_store(32'h6000); step();
        do_load(32'h6100, 7, 0); step();
        do_store(32'h6000); step();
        do_check(7, PASS, "R9 reload replaces entry"); step();

        do_load(32'h7000, 9, 0); step();
        do_store(32'h7000); do_check(9, REPLAY, "R11 store before check"); step();

        do_load(32'h8000, 10, 1); step();
        do_store(32'h8000); step();
        do_check(10, RAISE, "R12 fault over alias"); step();

        do_check(20, REPLAY, "R7 untracked register"); step();

        for (int i = 0; i < 8; i++) begin
            do_load(32'h9000 + 32'(i) * 32'h40, 11 + i, 0); step();
        end
        do_load(32'hA000, 19, 0); step();
        do_load(32'hA100, 22, 0); step();
        do_check(11, REPLAY, "R10 slot 0 replaced"); step();
        do_check(12, REPLAY, "R10 slot 1 replaced"); step();
        do_check(13, PASS, "R10 slot 2 kept"); step();
        do_check(19, PASS, "R10 first newcomer"); step();
        do_check(22, PASS, "R10 second newcomer"); step();

        step(); step();
        check(exp_code_q.size() == 0, "R2 every check answered", exp_code_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule